// File: doc/BRIEF.md
# Interruptible Multi-Register Transfer Sequencer

This block turns a multi-register load or store command into a series of single-word bus beats and decides how the operation gives way when an interrupt becomes pending. Integer and vector multi-register transfers, including stack push and pop, stop only at a beat boundary. When they stop early they report a continuation index, which is the next register still owed. When that index is handed back with the same command later, the transfer picks up where it left off. Doubleword transfers and the multi-cycle divide keep no partial progress. If interrupted, they are dropped and must be issued again from the start.

The surrounding pipeline issues one command at a time on the command port. It answers each beat on a request/acknowledge bus port and supplies the interrupt-pending level. It watches three one-cycle termination pulses: done, suspend and restart. The register file contents, stacking and the rest of the pipeline are outside the block.

Top module: `mreg_xfer_seq`

## Requirements
- R1: Operation codes on `cmd_op` are 0 load-multiple, 1 store-multiple, 2 push, 3 pop, 4 vector load-multiple, 5 vector store-multiple, 6 doubleword load, 7 doubleword store, 8 divide. Codes 9 to 15 finish with a done pulse and no beat. `cmd_ready` is high exactly when no operation is in progress, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: A multi-register operation issues one beat per set bit of `cmd_reglist`, in ascending register order. `bus_reg` carries the register index. The first beat is at `cmd_base`, and each later beat is at the previous address plus 4. `bus_req` and the beat fields stay steady until `bus_ack`. `bus_we` is 1 for codes 1, 2, 5 and 7 and 0 otherwise.
- R3: After the acknowledge of the last owed beat, `done_o` pulses in the following cycle. A multi-register command that owes no register produces a done pulse one cycle after acceptance and no beat.
- R4: If `irq_pending` is high on the edge that acknowledges a multi-register beat and registers remain, no further beat is issued. `susp_o` then pulses in the next cycle, with `susp_idx` equal to the next set register index. If no register remains, the operation completes with done instead.
- R5: An interrupt already pending when a multi-register command is accepted does not prevent its first beat.
- R6: When `cmd_resume_valid` is 1 on a multi-register command, beats start at the lowest set bit whose index is at least `cmd_resume_idx`. The first address is `cmd_base` plus 4 times the number of set bits below that index. When it is 0, beats start at the lowest set bit.
- R7: Vector load-multiple and store-multiple follow R2 to R6 exactly as their integer forms do.
- R8: A doubleword operation issues two beats: first register r at `cmd_base`, then register r+1 (mod 16) at `cmd_base`+4. Here r is the lowest set bit of `cmd_reglist`, or 0 if the list is empty. An interrupt pending at the first acknowledge gives a restart pulse and no second beat. The resume fields are ignored.
- R9: Divide issues no beat and takes `DIV_CYCLES` cycles, then pulses done. If `irq_pending` is high in any of those cycles, it pulses `restart_o` in the next cycle instead.
- R10: Each accepted operation ends with exactly one of done, suspend or restart, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 4 | Operation code (R1) |
| cmd_reglist | input | NREG | Register list, one bit per register |
| cmd_base | input | AW | Address of the lowest listed register |
| cmd_resume_valid | input | 1 | Continuation index is valid |
| cmd_resume_idx | input | IW | Continuation index from an earlier suspend |
| bus_req | output | 1 | Beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | AW | Beat address |
| bus_reg | output | IW | Register index of the beat |
| bus_ack | input | 1 | Beat accepted |
| irq_pending | input | 1 | Interrupt pending level |
| done_o | output | 1 | Operation completed |
| susp_o | output | 1 | Operation suspended, continuation valid |
| susp_idx | output | IW | Next register owed, valid with susp_o |
| restart_o | output | 1 | Operation abandoned, reissue from start |

## Verification
The bench targets interrupts on the final beat, which must give done and not a suspend. A design that checked only the interrupt would report a continuation past the end of the list. It also drives interrupts already pending at acceptance. A design that yielded before the first beat would suspend with nothing transferred and could livelock. Resumes are tried with indices that fall between set bits or beyond all of them. A wrong start address or skipped register shows up as a mismatched beat. Doubleword interrupts on either half and divide interrupts in the first and last cycle are also covered. A design that kept partial progress, or restarted after completion, would give the wrong termination pulse or beat count.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [3:0] {
    OP_LDM  = 4'd0,
    OP_STM  = 4'd1,
    OP_PUSH = 4'd2,
    OP_POP  = 4'd3,
    OP_VLDM = 4'd4,
    OP_VSTM = 4'd5,
    OP_LDRD = 4'd6,
    OP_STRD = 4'd7,
    OP_DIV  = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DIV  = 2'd2
  } st_e;

  function automatic logic op_is_multi(input logic [3:0] op);
    return (op <= 4'd5);
  endfunction

  function automatic logic op_is_dword(input logic [3:0] op);
    return (op == OP_LDRD) || (op == OP_STRD);
  endfunction

  function automatic logic op_is_store(input logic [3:0] op);
    return (op == OP_STM) || (op == OP_PUSH) || (op == OP_VSTM) || (op == OP_STRD);
  endfunction
endpackage

// File: rtl/mxs_scan.sv
// Lowest set bit of a list at or above a start index.
module mxs_scan #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  list,
  input  logic [IW:0]   from,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (list[i] && ((IW+1)'(i) >= from)) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mxs_popbelow.sv
// Number of set bits strictly below a given index.
module mxs_popbelow #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  list,
  input  logic [IW-1:0] lim,
  output logic [IW:0]   cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      if (list[i] && ((IW+1)'(i) < {1'b0, lim})) cnt = cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
  import mxs_pkg::*;
#(
  parameter int NREG       = 16,
  parameter int AW         = 32,
  parameter int DIV_CYCLES = 12,
  localparam int IW        = $clog2(NREG),
  localparam int CW        = $clog2(DIV_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [3:0]    cmd_op,
  input  logic [NREG-1:0] cmd_reglist,
  input  logic [AW-1:0] cmd_base,
  input  logic          cmd_resume_valid,
  input  logic [IW-1:0] cmd_resume_idx,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [IW-1:0] bus_reg,
  input  logic          bus_ack,
  input  logic          irq_pending,
  output logic          done_o,
  output logic          susp_o,
  output logic [IW-1:0] susp_idx,
  output logic          restart_o
);

  st_e             st_q, st_d;
  logic [3:0]      op_q, op_d;
  logic [NREG-1:0] list_q, list_d;
  logic [IW-1:0]   cur_q, cur_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic            half_q, half_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d, susp_q, susp_d, rst_q, rst_d;
  logic [IW-1:0]   sidx_q, sidx_d;

  // first register of a new command
  logic [IW:0]     first_from;
  logic            first_found;
  logic [IW-1:0]   first_idx;
  logic [IW:0]     skipped;
  // next register after the current beat
  logic            next_found;
  logic [IW-1:0]   next_idx;

  logic accept, beat_end;

  assign accept     = cmd_valid && (st_q == ST_IDLE);
  assign beat_end   = (st_q == ST_BEAT) && bus_ack;
  assign first_from = (op_is_multi(cmd_op) && cmd_resume_valid) ? {1'b0, cmd_resume_idx} : '0;

  mxs_scan #(.N(NREG), .IW(IW)) i_first_scan (
    .list (cmd_reglist),
    .from (first_from),
    .found(first_found),
    .idx  (first_idx)
  );

  mxs_popbelow #(.N(NREG), .IW(IW)) i_skip_cnt (
    .list(cmd_reglist),
    .lim (first_idx),
    .cnt (skipped)
  );

  mxs_scan #(.N(NREG), .IW(IW)) i_next_scan (
    .list (list_q),
    .from ({1'b0, cur_q} + 1'b1),
    .found(next_found),
    .idx  (next_idx)
  );

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    list_d = list_q;
    cur_d  = cur_q;
    addr_d = addr_q;
    half_d = half_q;
    cnt_d  = cnt_q;
    sidx_d = sidx_q;
    done_d = 1'b0;
    susp_d = 1'b0;
    rst_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          op_d   = cmd_op;
          list_d = cmd_reglist;
          half_d = 1'b0;
          cnt_d  = '0;
          cur_d  = first_idx;
          if (op_is_multi(cmd_op)) begin
            if (first_found) begin
              st_d   = ST_BEAT;
              addr_d = cmd_base + AW'({skipped, 2'b00});
            end else begin
              done_d = 1'b1;
            end
          end else if (op_is_dword(cmd_op)) begin
            st_d   = ST_BEAT;
            addr_d = cmd_base;
          end else if (cmd_op == OP_DIV) begin
            st_d = ST_DIV;
          end else begin
            done_d = 1'b1;
          end
        end
      end
      ST_BEAT: begin
        if (bus_ack) begin
          if (op_is_dword(op_q)) begin
            if (half_q) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else if (irq_pending) begin
              st_d  = ST_IDLE;
              rst_d = 1'b1;
            end else begin
              half_d = 1'b1;
              cur_d  = cur_q + 1'b1;
              addr_d = addr_q + AW'(4);
            end
          end else begin
            if (!next_found) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end else if (irq_pending) begin
              st_d   = ST_IDLE;
              susp_d = 1'b1;
              sidx_d = next_idx;
            end else begin
              cur_d  = next_idx;
              addr_d = addr_q + AW'(4);
            end
          end
        end
      end
      ST_DIV: begin
        if (irq_pending) begin
          st_d  = ST_IDLE;
          rst_d = 1'b1;
        end else if (cnt_q == CW'(DIV_CYCLES - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      list_q <= '0;
      cur_q  <= '0;
      addr_q <= '0;
      half_q <= 1'b0;
      cnt_q  <= '0;
      sidx_q <= '0;
      done_q <= 1'b0;
      susp_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      susp_q <= susp_d;
      rst_q  <= rst_d;
      if (accept || beat_end) begin
        op_q   <= op_d;
        list_q <= list_d;
        cur_q  <= cur_d;
        addr_q <= addr_d;
        half_q <= half_d;
      end
      if (accept || (st_q == ST_DIV)) cnt_q <= cnt_d;
      if (susp_d) sidx_q <= sidx_d;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign bus_req   = (st_q == ST_BEAT);
  assign bus_we    = op_is_store(op_q);
  assign bus_addr  = addr_q;
  assign bus_reg   = cur_q;
  assign done_o    = done_q;
  assign susp_o    = susp_q;
  assign restart_o = rst_q;
  assign susp_idx  = sidx_q;

  // R2: a pending beat holds its request and fields
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_reg) && $stable(bus_we)));

  // R2: back-to-back beats of one operation step the address by one word
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) ##1 bus_req |-> (bus_addr == $past(bus_addr) + AW'(4)));

  // R4: a suspend follows an acknowledged beat with the interrupt pending
  assert_susp_at_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_o |-> $past(bus_req && bus_ack && irq_pending));

  // R4: suspend is only taken by multi-register operations
  assert_susp_multi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    susp_o |-> op_is_multi(op_q));

  // R5: an accepted multi-register command with work to do requests a beat next
  assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_is_multi(cmd_op) && first_found) |=> bus_req);

  // R8: a doubleword restart happens only on an acknowledged first half
  assert_dw_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && op_is_dword(op_q)) |-> $past(bus_req && bus_ack && irq_pending));

  // R9: a divide restart is caused by a pending interrupt
  assert_div_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_o && (op_q == OP_DIV)) |-> $past(irq_pending));

  // R10: at most one termination pulse at a time
  assert_one_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, susp_o, restart_o}));

endmodule

// File: tb/test_mreg_xfer_seq.sv
module test_mreg_xfer_seq;
  localparam int NREG = 16;
  localparam int AW   = 32;
  localparam int DIVC = 12;

  logic clk, rst_n;
  logic cmd_valid, cmd_ready;
  logic [3:0] cmd_op;
  logic [15:0] cmd_reglist;
  logic [31:0] cmd_base;
  logic cmd_resume_valid;
  logic [3:0] cmd_resume_idx;
  logic bus_req, bus_we, bus_ack, irq_pending;
  logic [31:0] bus_addr;
  logic [3:0] bus_reg;
  logic done_o, susp_o, restart_o;
  logic [3:0] susp_idx;

  int n_chk = 0;
  int n_fail = 0;

  mreg_xfer_seq #(.NREG(NREG), .AW(AW), .DIV_CYCLES(DIVC)) i_mreg_xfer_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_reglist(cmd_reglist), .cmd_base(cmd_base),
    .cmd_resume_valid(cmd_resume_valid), .cmd_resume_idx(cmd_resume_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_reg(bus_reg),
    .bus_ack(bus_ack), .irq_pending(irq_pending),
    .done_o(done_o), .susp_o(susp_o), .susp_idx(susp_idx), .restart_o(restart_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_store(input logic [3:0] op);
    return op == 4'd1 || op == 4'd2 || op == 4'd5 || op == 4'd7;
  endfunction

  // term codes: 0 done, 1 suspend, 2 restart
  task automatic run_op(input logic [3:0] op, input logic [15:0] lst, input logic [31:0] base,
                        input logic rv, input logic [3:0] ridx, input int irqb, input bit early,
                        input string tag);
    int ereg[17];
    logic [31:0] eaddr[17];
    int en, eterm, esidx, ebusy;
    int areg[17];
    logic [31:0] aaddr[17];
    logic awe[17];
    int nb, aterm, asidx, busy;
    bit seen;
    en = 0; eterm = 0; esidx = 0; ebusy = -1;
    if (op <= 4'd5) begin
      int st, k;
      st = rv ? int'(ridx) : 0;
      for (int r = st; r < 16; r++) begin
        if (lst[r]) begin
          int below;
          below = 0;
          for (int j = 0; j < r; j++) if (lst[j]) below++;
          ereg[en] = r;
          eaddr[en] = base + 32'(4 * below);
          en++;
        end
      end
      k = early ? 0 : irqb;
      if (k >= 0 && k < en - 1) begin
        eterm = 1; esidx = ereg[k+1]; en = k + 1;
      end
    end else if (op == 4'd6 || op == 4'd7) begin
      int r;
      r = 0;
      for (int j = 15; j >= 0; j--) if (lst[j]) r = j;
      ereg[0] = r; ereg[1] = (r + 1) % 16;
      eaddr[0] = base; eaddr[1] = base + 32'd4;
      if (early || irqb == 0) begin eterm = 2; en = 1; end else en = 2;
    end else if (op == 4'd8) begin
      int k;
      k = early ? 0 : irqb;
      if (k >= 0 && k < DIVC) begin eterm = 2; ebusy = k + 1; end else ebusy = DIVC;
    end

    @(negedge clk);
    chk(cmd_ready == 1'b1, {"R1 ready idle ", tag}, cmd_ready, 1);
    cmd_op = op; cmd_reglist = lst; cmd_base = base;
    cmd_resume_valid = rv; cmd_resume_idx = ridx;
    cmd_valid = 1'b1; irq_pending = early;
    @(negedge clk);
    cmd_valid = 1'b0;
    nb = 0; aterm = -1; asidx = 0; busy = 0; seen = 1'b0;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (done_o || susp_o || restart_o) begin
        chk((32'(done_o) + 32'(susp_o) + 32'(restart_o)) == 1, {"R10 single pulse ", tag},
            {done_o, susp_o, restart_o}, 0);
        aterm = done_o ? 0 : (susp_o ? 1 : 2);
        asidx = int'(susp_idx);
        seen = 1'b1;
        break;
      end
      if (cyc == 0) chk(cmd_ready == 1'b0, {"R1 busy not ready ", tag}, cmd_ready, 0);
      busy++;
      if (bus_req) begin
        bit ack;
        ack = ($urandom % 3) != 0;
        if (ack && nb < 17) begin
          areg[nb] = int'(bus_reg); aaddr[nb] = bus_addr; awe[nb] = bus_we;
          irq_pending = early || (nb == irqb);
          nb++;
        end else irq_pending = early;
        bus_ack = ack;
      end else begin
        irq_pending = early || (op == 4'd8 && cyc == irqb);
        bus_ack = 1'b0;
      end
      @(negedge clk);
      bus_ack = 1'b0;
    end
    irq_pending = 1'b0;
    chk(seen, {"R10 termination seen ", tag}, seen, 1);
    chk(aterm == eterm, {"R3 R4 R8 R9 termination kind ", tag}, aterm, eterm);
    if (eterm == 1) chk(asidx == esidx, {"R4 R6 continuation index ", tag}, asidx, esidx);
    chk(nb == en, {"R2 R3 beat count ", tag}, nb, en);
    if (ebusy >= 0) chk(busy == ebusy, {"R9 divide cycles ", tag}, busy, ebusy);
    for (int i = 0; i < nb && i < en; i++) begin
      chk(areg[i] == ereg[i], {"R2 R6 R7 R8 beat register ", tag}, areg[i], ereg[i]);
      chk(aaddr[i] == eaddr[i], {"R2 R6 R7 R8 beat address ", tag}, aaddr[i], eaddr[i]);
      chk(awe[i] == is_store(op), {"R2 beat direction ", tag}, awe[i], is_store(op));
    end
    @(negedge clk);
    chk(!(done_o || susp_o || restart_o), {"R10 pulse one cycle ", tag},
        {done_o, susp_o, restart_o}, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", wd, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_reglist = '0; cmd_base = '0;
    cmd_resume_valid = 1'b0; cmd_resume_idx = '0; bus_ack = 1'b0; irq_pending = 1'b0;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
    chk(bus_req == 1'b0, "R2 reset no request", bus_req, 0);
    chk(!(done_o || susp_o || restart_o), "R10 reset no pulse", {done_o, susp_o, restart_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(4'd0, 16'h8421, 32'h1000, 0, 0, -1, 0, "ldm plain");
    run_op(4'd1, 16'h00F0, 32'h2000, 0, 0, 1, 0, "stm irq beat1");
    run_op(4'd2, 16'h5005, 32'h3000, 0, 0, -1, 1, "push irq early R5");
    run_op(4'd3, 16'hFFFF, 32'h4000, 1, 4'd5, -1, 0, "pop resume 5");
    run_op(4'd3, 16'hA0A1, 32'h4100, 1, 4'd6, 0, 0, "pop resume gap");
    run_op(4'd4, 16'h0001, 32'h5000, 0, 0, -1, 1, "vldm single early R7");
    run_op(4'd5, 16'h0C30, 32'h5100, 0, 0, 0, 0, "vstm irq beat0 R7");
    run_op(4'd1, 16'h0000, 32'h6000, 0, 0, -1, 0, "stm empty");
    run_op(4'd0, 16'h000F, 32'h6100, 1, 4'd8, -1, 0, "ldm resume past end");
    run_op(4'd0, 16'h0003, 32'h6200, 0, 0, 1, 0, "ldm irq last beat");
    run_op(4'd6, 16'h0030, 32'h7000, 0, 0, 0, 0, "ldrd irq first half");
    run_op(4'd7, 16'h8000, 32'h7100, 0, 0, 1, 0, "strd irq second half");
    run_op(4'd6, 16'h0000, 32'h7200, 1, 4'd9, -1, 0, "ldrd resume ignored");
    run_op(4'd8, 16'h0000, 32'h0, 0, 0, -1, 0, "div full");
    run_op(4'd8, 16'h0000, 32'h0, 0, 0, 0, 0, "div irq first");
    run_op(4'd8, 16'h0000, 32'h0, 0, 0, DIVC - 1, 0, "div irq last");
    run_op(4'hF, 16'hFFFF, 32'h0, 0, 0, -1, 0, "invalid op R1");

    for (int t = 0; t < 80; t++) begin
      logic [3:0] op;
      logic [15:0] lst;
      int ib;
      op  = 4'($urandom_range(0, 9));
      lst = 16'($urandom);
      if (($urandom % 4) == 0) lst = lst & 16'($urandom);
      ib  = ($urandom % 3 == 0) ? -1 : int'($urandom_range(0, 14));
      run_op(op, lst, {16'($urandom), 14'($urandom), 2'b00}, 1'($urandom), 4'($urandom),
             ib, ($urandom % 8) == 0, "random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule